// File: doc/BRIEF.md
# Serial-Bus Wiper Register Slave

This block is a two-wire serial bus (I2C) slave that owns one 7-bit volatile wiper position, the control word of a digitally controlled potentiometer. Both bus lines are brought into a fast system clock domain through a synchronizer. Clock edges and bus conditions are found by oversampling. SDA leaves the block only as an open-drain enable: when `sda_oe` is high, the pad pulls the line low. The wiper value is presented in parallel on `wiper_o` and drives the resistor-tap decoder outside the block.

A host writes the wiper with a START, a write-mode identification byte, register address 00h, one data byte and a STOP. To read, the host sends a write-mode identification byte and the address, then a repeated START and a read-mode identification byte. It then clocks data bytes out until it withholds its acknowledge. For a fixed number of system cycles after reset the block ignores the bus. This models the power-up sequence.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset, `wiper_o` holds the mid-scale value 40h and `sda_oe` is low (SDA released).
- R2: For `PWRUP_CYCLES` system cycles after reset, a START is ignored, so no byte of that transfer is acknowledged.
- R3: The identification byte is acknowledged (SDA held low through the 9th SCL pulse) only when its upper seven bits equal `DEV_ID`, default 0101110. Its bit 0 selects read (1) or write (0). On a mismatch, no ACK is returned and every later byte is ignored until the next START.
- R4: Only address byte 00h is acknowledged. Any other address gets no ACK, and the data byte that follows does not change the wiper.
- R5: In a write, the data byte is acknowledged. Its lower 7 bits become the wiper value and its bit 7 is ignored. Bytes travel MSB first.
- R6: The wiper changes on the SCL falling edge that ends the data byte's LSB. This is before the acknowledge clock, and the wiper changes at no other time.
- R7: After a read-mode identification byte is acknowledged, the slave sends {0, wiper} MSB first. It sends it again for each byte that the master acknowledges.
- R8: When the master does not acknowledge a read byte, the slave leaves SDA released until the next START or STOP. SDA is also released whenever the slave is idle or waiting.
- R9: A START seen in any state restarts identification-byte reception with a cleared bit count. A STOP seen in any state returns the slave to idle. A write cut short by either leaves the wiper unchanged.
- R10: `sda_oe` only asserts while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; much faster than SCL |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| wiper_o | output | 7 | Current wiper position, 00h = low end, 7Fh = high end |

## Verification
A pad change passes through two synchronizer flops and one edge-detect flop. The resulting state, `sda_oe` or wiper update is therefore registered three system cycles after the SCL or SDA edge that caused it. The bench holds each bus level for five system cycles and samples outputs on the falling system clock at the end of those five cycles. This puts every sample two cycles after the result is due and before the next bus edge. The wiper is sampled twice: once while SCL is still high during the data LSB, and once five cycles after that SCL fall. This proves the update lands before the ACK clock. Acknowledges are read in the middle of the 9th SCL high phase.

// File: rtl/wpot_pkg.sv
`timescale 1ns/1ps
package wpot_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] WIPER_ADDR = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_ADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } wp_state_e;

    typedef enum logic [1:0] {
        NX_ADDR,
        NX_WDATA,
        NX_READ,
        NX_DONE
    } wp_next_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic id_match(input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-2:0] id);
        return b[BYTE_W-1:1] == id;
    endfunction

endpackage

// File: rtl/wpot_sync.sv
`timescale 1ns/1ps
module wpot_sync #(
    parameter int STAGES = 2,
    parameter int LANES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] dout
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], din[l]};
        end
        assign dout[l] = chain[STAGES-1];
    end
endmodule

// File: rtl/wpot_cond.sv
`timescale 1ns/1ps
module wpot_cond
    import wpot_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.sda   = sda_s;
    end
endmodule

// File: rtl/wpot_pwrup.sv
`timescale 1ns/1ps
module wpot_pwrup #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (busy) cnt <= cnt + 1'b1;
    end

    assign busy = (cnt != LIMIT);
endmodule

// File: rtl/wpot_fsm.sv
`timescale 1ns/1ps
module wpot_fsm
    import wpot_pkg::*;
#(
    parameter int               W         = 7,
    parameter logic [BYTE_W-2:0] DEV_ID    = 7'b0101110,
    parameter logic [W-1:0]     RESET_VAL = 7'h40
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_evt_t  evt,
    input  logic      pwr_busy,
    output logic [W-1:0] wiper,
    output logic      sda_oe,
    output wp_state_e state
);
    localparam logic [3:0] LAST_RX = 4'd8;
    localparam logic [3:0] LAST_TX = 4'd7;

    wp_next_e          nxt;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              mack;
    logic [BYTE_W-1:0] rd_byte;

    assign rd_byte = {{(BYTE_W-W){1'b0}}, wiper};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            nxt    <= NX_DONE;
            bitcnt <= '0;
            shreg  <= '0;
            txreg  <= '0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
            wiper  <= RESET_VAL;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            bitcnt <= '0;
        end else if (evt.start && !pwr_busy) begin
            state  <= ST_ID;
            sda_oe <= 1'b0;
            bitcnt <= '0;
        end else begin
            case (state)
                ST_ID, ST_ADDR, ST_WDATA: begin
                    if (evt.rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (evt.fall && bitcnt == LAST_RX) begin
                        state <= ST_WAIT;
                        if (state == ST_ID) begin
                            if (id_match(shreg, DEV_ID)) begin
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                nxt    <= shreg[0] ? NX_READ : NX_ADDR;
                            end
                        end else if (state == ST_ADDR) begin
                            if (shreg == WIPER_ADDR) begin
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                nxt    <= NX_WDATA;
                            end
                        end else begin
                            wiper  <= shreg[W-1:0];
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                            nxt    <= NX_DONE;
                        end
                    end
                end
                ST_ACK: begin
                    if (evt.fall) begin
                        bitcnt <= '0;
                        case (nxt)
                            NX_ADDR: begin
                                sda_oe <= 1'b0;
                                state  <= ST_ADDR;
                            end
                            NX_WDATA: begin
                                sda_oe <= 1'b0;
                                state  <= ST_WDATA;
                            end
                            NX_READ: begin
                                txreg  <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                state  <= ST_RDATA;
                            end
                            default: begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_RDATA: begin
                    if (evt.fall) begin
                        if (bitcnt == LAST_TX) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_RACK;
                        end else begin
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~txreg[BYTE_W-2];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (evt.rise) begin
                        mack <= ~evt.sda;
                    end else if (evt.fall) begin
                        if (mack) begin
                            txreg  <= rd_byte;
                            sda_oe <= ~rd_byte[BYTE_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wiper_i2c_slave.sv
`timescale 1ns/1ps
module wiper_i2c_slave
    import wpot_pkg::*;
#(
    parameter int                W            = 7,
    parameter logic [BYTE_W-2:0] DEV_ID       = 7'b0101110,
    parameter logic [W-1:0]      RESET_VAL    = 7'h40,
    parameter int                SYNC_STAGES  = 2,
    parameter int                PWRUP_CYCLES = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scl_i,
    input  logic         sda_i,
    output logic         sda_oe,
    output logic [W-1:0] wiper_o
);
    localparam int LANES = 2;

    logic [LANES-1:0] lines_s;
    logic             scl_s, sda_s;
    bus_evt_t         evt;
    logic             pwr_busy;
    wp_state_e        fsm_state;

    wpot_sync #(.STAGES(SYNC_STAGES), .LANES(LANES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_i, sda_i}),
        .dout (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    wpot_cond cond_i (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt   (evt)
    );

    wpot_pwrup #(.CYCLES(PWRUP_CYCLES)) pwrup_i (
        .clk  (clk),
        .rst  (rst),
        .busy (pwr_busy)
    );

    wpot_fsm #(.W(W), .DEV_ID(DEV_ID), .RESET_VAL(RESET_VAL)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .pwr_busy (pwr_busy),
        .wiper    (wiper_o),
        .sda_oe   (sda_oe),
        .state    (fsm_state)
    );
endmodule

// File: rtl/wpot_chk.sv
`timescale 1ns/1ps
module wpot_chk
    import wpot_pkg::*;
#(
    parameter int           W         = 7,
    parameter logic [W-1:0] RESET_VAL = 7'h40
) (
    input logic         clk,
    input logic         rst,
    input logic         scl_s,
    input logic         fall_ev,
    input logic         pwr_busy,
    input wp_state_e    state,
    input logic         sda_oe,
    input logic [W-1:0] wiper
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wiper == RESET_VAL && !sda_oe));

    p_pwrup_idle_r2: assert property (@(posedge clk) disable iff (rst)
        pwr_busy |-> state == ST_IDLE);

    p_wiper_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper) |-> $past(fall_ev));

    p_released_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_WAIT) |-> !sda_oe);

    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_s));
endmodule

bind wiper_i2c_slave wpot_chk #(.W(W), .RESET_VAL(RESET_VAL)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .fall_ev  (evt.fall),
    .pwr_busy (pwr_busy),
    .state    (fsm_state),
    .sda_oe   (sda_oe),
    .wiper    (wiper_o)
);

// File: tb/wiper_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module wiper_i2c_slave_tb_top;
    localparam int       Q      = 5;
    localparam logic [6:0] ID   = 7'b0101110;
    localparam logic [7:0] ID_W = {ID, 1'b0};
    localparam logic [7:0] ID_R = {ID, 1'b1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [6:0] wiper_o;
    logic       sda_bus;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    wiper_i2c_slave dut_i (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (m_scl),
        .sda_i   (sda_bus),
        .sda_oe  (sda_oe),
        .wiper_o (wiper_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack,
                           output logic [6:0] w_hi, output logic [6:0] w_lo);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw();
            m_scl = 1'b1; qw();
            if (i == 0) w_hi = wiper_o;
            qw();
            m_scl = 1'b0; qw();
            if (i == 0) w_lo = wiper_o;
        end
        m_sda = 1'b1;
        m_scl = 1'b1; qw();
        ack = ~sda_bus;
        qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            m_scl = 1'b1; qw();
            d[i] = sda_bus;
            qw();
            m_scl = 1'b0;
        end
        qw();
        m_sda = ~give_ack;
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
        m_sda = 1'b1;
    endtask

    task automatic full_write(input logic [7:0] d, input logic [6:0] prev, input bit deep);
        logic a;
        logic [6:0] hi, lo;
        bus_start();
        wr_byte(ID_W, a, hi, lo);
        if (deep) chk("R3 id ack", a, 1);
        wr_byte(8'h00, a, hi, lo);
        if (deep) chk("R4 addr 00 ack", a, 1);
        wr_byte(d, a, hi, lo);
        chk("R5 data ack", a, 1);
        chk("R6 wiper held before LSB fall", hi, prev);
        chk("R6 wiper updated before ack clock", lo, d[6:0]);
        bus_stop();
        chk("R5 wiper after write", wiper_o, d[6:0]);
    endtask

    task automatic do_read(input logic [6:0] exp_w);
        logic a;
        logic [6:0] hi, lo;
        logic [7:0] d;
        bus_start();
        wr_byte(ID_W, a, hi, lo);
        wr_byte(8'h00, a, hi, lo);
        bus_start();
        wr_byte(ID_R, a, hi, lo);
        chk("R3 read id ack", a, 1);
        for (int k = 0; k < 3; k++) begin
            rd_byte(k != 2, d);
            chk("R7 read byte", d, {1'b0, exp_w});
        end
        chk("R8 released after nack", sda_oe, 0);
        qw();
        chk("R8 still released", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [6:0] hi, lo, cur;
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset wiper", wiper_o, 7'h40);
        chk("R1 reset sda_oe", sda_oe, 0);

        // R2: transfer started inside power-up window
        bus_start();
        wr_byte(ID_W, a, hi, lo);
        chk("R2 start ignored in power-up", a, 0);
        wr_byte(8'h00, a, hi, lo);
        wr_byte(8'h11, a, hi, lo);
        bus_stop();
        chk("R2 wiper untouched", wiper_o, 7'h40);
        repeat (100) @(negedge clk);

        // R5/R6 sweep of every wiper code with bit 7 varied
        cur = 7'h40;
        for (int v = 0; v < 128; v++) begin
            d = {v[0] ^ v[3], 7'(v)};
            full_write(d, cur, 1'b1);
            cur = 7'(v);
            if (v % 16 == 5) do_read(cur);
        end

        // R3: identifier mismatch, each bit flipped
        for (int k = 0; k < 7; k++) begin
            bus_start();
            wr_byte({ID ^ 7'(1 << k), 1'b0}, a, hi, lo);
            chk("R3 wrong id no ack", a, 0);
            wr_byte(8'h00, a, hi, lo);
            chk("R3 addr ignored after bad id", a, 0);
            wr_byte(8'h05, a, hi, lo);
            chk("R3 data ignored after bad id", a, 0);
            bus_stop();
            chk("R3 wiper unchanged", wiper_o, cur);
        end

        // R4: non-zero addresses
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ad;
            ad = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : (k == 2) ? 8'hFF : 8'h10;
            bus_start();
            wr_byte(ID_W, a, hi, lo);
            chk("R4 id ack", a, 1);
            wr_byte(ad, a, hi, lo);
            chk("R4 bad addr no ack", a, 0);
            wr_byte(8'h22, a, hi, lo);
            chk("R4 data no ack", a, 0);
            bus_stop();
            chk("R4 wiper unchanged", wiper_o, cur);
        end

        // R9: repeated START mid data byte, then a clean write
        bus_start();
        wr_byte(ID_W, a, hi, lo);
        wr_byte(8'h00, a, hi, lo);
        for (int k = 0; k < 4; k++) send_bit(1'b0);
        chk("R9 partial byte no effect", wiper_o, cur);
        bus_start();
        wr_byte(ID_W, a, hi, lo);
        chk("R9 id acked after restart", a, 1);
        wr_byte(8'h00, a, hi, lo);
        wr_byte(8'h2A, a, hi, lo);
        bus_stop();
        chk("R9 write after restart", wiper_o, 7'h2A);
        cur = 7'h2A;

        // R9: STOP mid data byte
        bus_start();
        wr_byte(ID_W, a, hi, lo);
        wr_byte(8'h00, a, hi, lo);
        for (int k = 0; k < 3; k++) send_bit(1'b1);
        bus_stop();
        chk("R9 stop aborts write", wiper_o, cur);
        chk("R8 released after stop", sda_oe, 0);
        full_write(8'h7F, cur, 1'b1);
        do_read(7'h7F);
        full_write(8'h80, 7'h7F, 1'b1);
        do_read(7'h00);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule